// File: doc/BRIEF.md
# Oversampled Serial Receiver with Overrun Discard

This block takes one asynchronous serial input line and turns each character on it into an 8-bit value in a receive buffer. The line is first synchronised to the clock. It is then sampled sixteen times per bit period. Each bit is decided by a majority vote of three samples taken around the middle of the bit. A character is made of a low start bit, eight data bits sent least significant first, an optional parity bit and a high stop bit. Only the eight data bits are kept.

A finished character goes into the buffer only if the buffer is free. If the buffer still holds an unread value, the new character is dropped and the old value stays; an overrun flag records this. The block also flags a low stop bit (framing) and a parity mismatch. A one-cycle interrupt pulse marks every buffer load. A read strobe on the buffer releases it. The error flags clear only when a status-read strobe comes first and a buffer read follows it.

The receive enable is taken into account only while the receiver waits for a start bit. If the enable is cleared in the middle of a character, that character still completes. `rx_on` shows whether the receiver is active.

The control is one state machine:
- States: `S_OFF` (disabled), `S_IDLE` (waiting for a start edge), `S_START`, `S_DATA`, `S_PAR`, `S_STOP` and `S_RECOVER` (waiting for a high line after a framing error).
- Transitions:
  - OFF→IDLE when enabled. IDLE→OFF when the enable is low.
  - IDLE→START on a low line.
  - START→IDLE when the mid-bit vote is high (glitch). START→DATA at the end of the bit.
  - DATA→PAR or DATA→STOP after the eighth bit.
  - PAR→STOP at the end of the bit.
  - STOP→IDLE on a high stop vote. STOP→RECOVER on a low stop vote.
  - RECOVER→IDLE once the line is high.

Top module: `serial_rx_unit`

## Requirements
- R1: After reset, `rx_data` is 0. `buf_full`, `ovr_err`, `frm_err`, `par_err`, `rx_irq` and `rx_on` are all 0.
- R2: A character is a low start bit, 8 data bits least significant first, an optional parity bit and one high stop bit. When the stop bit's mid vote is high and the buffer is free, the data goes to `rx_data`, `buf_full` is set, and `rx_irq` pulses high for exactly one cycle.
- R3: The bit period is 16 sample ticks. A tick comes every `BASE_DIV << baud_sel` clocks. Each bit value is the majority of the samples at ticks 7, 8 and 9 of the bit.
- R4: A low pulse on an idle line is rejected as a glitch if the start-bit vote is high. A rejected pulse loads nothing, and a following valid character is received correctly.
- R5: When `par_en` is 1, a parity bit follows the data. The expected parity is even when `par_odd` is 0: data bits plus parity bit hold an even number of ones. It is odd when `par_odd` is 1. A mismatch sets `par_err`, and the data is still loaded.
- R6: A low stop vote sets `frm_err` and loads nothing. The receiver then waits for a high line before it accepts a new start bit.
- R7: When a character completes while `buf_full` is 1 and no buffer read happens in that cycle, `ovr_err` is set. The new data is discarded, `rx_data` is unchanged, and no `rx_irq` pulse is given.
- R8: A `buf_rd` pulse clears `buf_full`.
- R9: A `buf_rd` pulse alone leaves the error flags set. A `stat_rd` pulse followed by a later `buf_rd` pulse clears `ovr_err`, `frm_err` and `par_err`.
- R10: Clearing `rx_en` during a character does not stop it. The character is received in full, and `rx_on` falls only after the character ends.
- R11: While `rx_on` is 0, activity on `rx_line` loads nothing and raises no interrupt.
- R12: With `baud_sel` set to 1 or 2, characters sent at the matching slower rate are received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| rx_en | input | 1 | Receive enable, applied between characters |
| par_en | input | 1 | 1: a parity bit follows the data |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| baud_sel | input | 2 | Tick divider is BASE_DIV shifted left by this value |
| stat_rd | input | 1 | Status-read strobe; arms error clearing |
| buf_rd | input | 1 | Buffer-read strobe; frees the buffer |
| rx_data | output | 8 | Receive buffer |
| buf_full | output | 1 | Buffer holds an unread character |
| ovr_err | output | 1 | Character dropped because the buffer was full |
| frm_err | output | 1 | Stop bit was low |
| par_err | output | 1 | Parity mismatch |
| rx_irq | output | 1 | One-cycle pulse on each buffer load |
| rx_on | output | 1 | Receiver is active |

## Verification
The assertions assume that `par_en`, `par_odd` and `baud_sel` do not change while a character is in progress. They also assume that `stat_rd` and `buf_rd` are single-cycle strobes. The stimulus changes configuration only after the line has been idle for two bit periods. It drives every serial bit for a whole number of bit periods at the selected rate, and it raises each strobe for one clock at a falling clock edge. Glitch and framing cases are the only deliberate breaks in the frame format, and they are driven as separate, timed events.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    typedef enum logic [2:0] {
        S_OFF,
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP,
        S_RECOVER
    } rx_state_e;

    function automatic logic vote3(input logic [2:0] s);
        return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
    endfunction

endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/serial_rx_baud.sv
module serial_rx_baud #(
    parameter int BASE_DIV = 2,
    parameter int SEL_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int MAX_DIV = BASE_DIV << ((1 << SEL_W) - 1);
    localparam int CW      = $clog2(MAX_DIV + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    assign lim  = (CW'(BASE_DIV) << sel) - CW'(1);
    assign tick = (cnt >= lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit
    import serial_rx_pkg::*;
#(
    parameter int BASE_DIV = 2,
    parameter int DATA_W   = 8,
    parameter int SEL_W    = 2,
    parameter int OSR      = 16,
    parameter int SYNC_N   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_line,
    input  logic              rx_en,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic [SEL_W-1:0]  baud_sel,
    input  logic              stat_rd,
    input  logic              buf_rd,
    output logic [DATA_W-1:0] rx_data,
    output logic              buf_full,
    output logic              ovr_err,
    output logic              frm_err,
    output logic              par_err,
    output logic              rx_irq,
    output logic              rx_on
);
    localparam int PH_W  = $clog2(OSR);
    localparam int IDX_W = $clog2(DATA_W);
    localparam int MID   = OSR / 2;

    rx_state_e         state, nxt;
    logic              rxs, tick;
    logic [PH_W-1:0]   phase;
    logic [IDX_W-1:0]  idx;
    logic [2:0]        smp;
    logic [DATA_W-1:0] shreg;
    logic              pbit, armed;
    logic              mid_ev, end_ev, vote_now, load_ev;

    serial_rx_sync #(.STAGES(SYNC_N)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rx_line), .dout(rxs)
    );

    serial_rx_baud #(.BASE_DIV(BASE_DIV), .SEL_W(SEL_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .sel(baud_sel), .tick(tick)
    );

    assign mid_ev   = tick && (phase == PH_W'(MID + 1));
    assign end_ev   = tick && (phase == PH_W'(OSR - 1));
    assign vote_now = vote3({smp[1:0], rxs});
    assign load_ev  = (state == S_STOP) && mid_ev && vote_now && !(buf_full && !buf_rd);
    assign rx_on    = (state != S_OFF);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_OFF;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_OFF:     if (rx_en) nxt = S_IDLE;
            S_IDLE:    if (!rx_en) nxt = S_OFF;
                       else if (!rxs) nxt = S_START;
            S_START:   if (mid_ev && vote_now) nxt = S_IDLE;
                       else if (end_ev) nxt = S_DATA;
            S_DATA:    if (end_ev && idx == IDX_W'(DATA_W - 1))
                           nxt = par_en ? S_PAR : S_STOP;
            S_PAR:     if (end_ev) nxt = S_STOP;
            S_STOP:    if (mid_ev) nxt = vote_now ? S_IDLE : S_RECOVER;
            S_RECOVER: if (rxs) nxt = S_IDLE;
            default:   nxt = S_OFF;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase    <= '0;
            idx      <= '0;
            smp      <= '1;
            shreg    <= '0;
            pbit     <= 1'b0;
            armed    <= 1'b0;
            rx_data  <= '0;
            buf_full <= 1'b0;
            ovr_err  <= 1'b0;
            frm_err  <= 1'b0;
            par_err  <= 1'b0;
            rx_irq   <= 1'b0;
        end else begin
            rx_irq <= 1'b0;

            if (state == S_IDLE || state == S_OFF)
                phase <= '0;
            else if (tick)
                phase <= (phase == PH_W'(OSR - 1)) ? '0 : phase + PH_W'(1);

            if (tick && phase >= PH_W'(MID - 1) && phase <= PH_W'(MID + 1))
                smp <= {smp[1:0], rxs};

            if (state == S_START)
                idx <= '0;
            else if (state == S_DATA && end_ev)
                idx <= idx + IDX_W'(1);

            if (state == S_DATA && mid_ev)
                shreg <= {vote_now, shreg[DATA_W-1:1]};
            if (state == S_PAR && mid_ev)
                pbit <= vote_now;

            // reader side first, so that new events win below
            if (stat_rd) armed <= 1'b1;
            if (buf_rd) begin
                buf_full <= 1'b0;
                if (armed) begin
                    ovr_err <= 1'b0;
                    frm_err <= 1'b0;
                    par_err <= 1'b0;
                    armed   <= 1'b0;
                end
            end

            if (state == S_STOP && mid_ev) begin
                if (!vote_now)
                    frm_err <= 1'b1;
                else if (!load_ev)
                    ovr_err <= 1'b1;
            end
            if (load_ev) begin
                rx_data  <= shreg;
                buf_full <= 1'b1;
                rx_irq   <= 1'b1;
                if (par_en && ((^shreg ^ pbit) != par_odd))
                    par_err <= 1'b1;
            end
        end
    end

    // R2: interrupt is a single-cycle pulse
    a_r2_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |=> !rx_irq);
    // R2: interrupt only accompanies a full buffer
    a_r2_irq_full: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> buf_full);
    // R7: an overrun leaves the buffer untouched
    a_r7_ovr_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_err) |-> ($stable(rx_data) && !rx_irq));
    // R8: a read with no load frees the buffer
    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_rd && !load_ev) |=> !buf_full);
    // R9: error flags survive while no read happens
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_err && !buf_rd) |=> ovr_err);
    // R10: a character in flight is never cut off by a disable
    a_r10_defer_off: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_START || state == S_DATA || state == S_PAR || state == S_STOP)
        |=> rx_on);
    // R6: a framing error never loads the buffer
    a_r6_frm_noload: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RECOVER) |-> !rx_irq);

endmodule

// File: tb/tb_serial_rx_unit.sv
`timescale 1ns/1ps
module tb_serial_rx_unit;
    localparam int BASE_DIV = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic       rx_en = 1'b0, par_en = 1'b0, par_odd = 1'b0;
    logic [1:0] baud_sel = 2'd0;
    logic       stat_rd = 1'b0, buf_rd = 1'b0;
    logic [7:0] rx_data;
    logic       buf_full, ovr_err, frm_err, par_err, rx_irq, rx_on;

    int n_run = 0, n_fail = 0, irq_cnt = 0;
    logic on_mid;

    always #2.5 clk = ~clk;

    serial_rx_unit #(.BASE_DIV(BASE_DIV)) dut (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .rx_en(rx_en),
        .par_en(par_en), .par_odd(par_odd), .baud_sel(baud_sel),
        .stat_rd(stat_rd), .buf_rd(buf_rd), .rx_data(rx_data),
        .buf_full(buf_full), .ovr_err(ovr_err), .frm_err(frm_err),
        .par_err(par_err), .rx_irq(rx_irq), .rx_on(rx_on)
    );

    always @(posedge clk) begin
        if (!rst_n) irq_cnt <= 0;
        else if (rx_irq) irq_cnt <= irq_cnt + 1;
    end

    // {data[7:0], par_en, par_odd, bad_parity, baud_sel[1:0], exp_par_err}
    localparam logic [13:0] VEC [7] = '{
        {8'hA5, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0},
        {8'h3C, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0},
        {8'h3C, 1'b1, 1'b0, 1'b1, 2'd0, 1'b1},
        {8'h81, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0},
        {8'h7E, 1'b1, 1'b1, 1'b1, 2'd0, 1'b1},
        {8'hC3, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0},
        {8'h5A, 1'b1, 1'b0, 1'b0, 2'd2, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int bitc();
        return 16 * (BASE_DIV << baud_sel);
    endfunction

    task automatic hold(input logic v, input int cycles);
        rx_line = v;
        repeat (cycles) @(negedge clk);
    endtask

    // drop_bit >= 0 clears rx_en at that data bit
    task automatic send(input logic [7:0] d, input logic bad_par,
                        input logic bad_stop, input int drop_bit);
        @(negedge clk);
        hold(1'b0, bitc());
        for (int i = 0; i < 8; i++) begin
            if (i == drop_bit) rx_en = 1'b0;
            hold(d[i], bitc());
            if (i == drop_bit) on_mid = rx_on;
        end
        if (par_en) hold((^d) ^ par_odd ^ bad_par, bitc());
        if (bad_stop) hold(1'b0, 2 * bitc());
        else          hold(1'b1, 2 * bitc());
    endtask

    task automatic strobe_stat();
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
    endtask

    task automatic strobe_buf();
        @(negedge clk); buf_rd = 1'b1;
        @(negedge clk); buf_rd = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int irq0;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 rx_data", rx_data, 0);
        chk("R1 flags", {buf_full, ovr_err, frm_err, par_err, rx_irq, rx_on}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rx_on after reset", rx_on, 0);
        rx_en = 1'b1;
        repeat (4) @(negedge clk);

        // table: R2 R3 R5 R12
        foreach (VEC[k]) begin
            par_en   = VEC[k][5];
            par_odd  = VEC[k][4];
            baud_sel = VEC[k][2:1];
            repeat (4) @(negedge clk);
            irq0 = irq_cnt;
            send(VEC[k][13:6], VEC[k][3], 1'b0, -1);
            chk("R2 R12 rx_data", rx_data, VEC[k][13:6]);
            chk("R2 buf_full", buf_full, 1);
            chk("R2 one irq", irq_cnt - irq0, 1);
            chk("R5 par_err", par_err, VEC[k][0]);
            strobe_stat();
            strobe_buf();
            chk("R8 buf released", buf_full, 0);
            chk("R9 par_err cleared", par_err, 0);
        end
        par_en = 1'b0; par_odd = 1'b0; baud_sel = 2'd0;
        repeat (4) @(negedge clk);

        // R4 glitch rejection
        irq0 = irq_cnt;
        hold(1'b0, 8);
        hold(1'b1, 3 * bitc());
        chk("R4 glitch no load", buf_full, 0);
        chk("R4 glitch no irq", irq_cnt - irq0, 0);
        send(8'h96, 1'b0, 1'b0, -1);
        chk("R4 frame after glitch", rx_data, 8'h96);
        strobe_buf();

        // R6 framing error and recovery
        irq0 = irq_cnt;
        send(8'h44, 1'b0, 1'b1, -1);
        chk("R6 frm_err", frm_err, 1);
        chk("R6 no load", buf_full, 0);
        chk("R6 no irq", irq_cnt - irq0, 0);
        hold(1'b1, 2 * bitc());
        send(8'h29, 1'b0, 1'b0, -1);
        chk("R6 recovered data", rx_data, 8'h29);
        strobe_buf();
        chk("R9 frm_err kept by buf read alone", frm_err, 1);
        strobe_stat();
        strobe_buf();
        chk("R9 frm_err cleared", frm_err, 0);

        // R7 overrun
        irq0 = irq_cnt;
        send(8'h11, 1'b0, 1'b0, -1);
        send(8'h22, 1'b0, 1'b0, -1);
        chk("R7 ovr_err", ovr_err, 1);
        chk("R7 data kept", rx_data, 8'h11);
        chk("R7 single irq", irq_cnt - irq0, 1);
        strobe_buf();
        chk("R8 buf_full cleared", buf_full, 0);
        chk("R9 ovr kept by buf read alone", ovr_err, 1);
        strobe_stat();
        strobe_buf();
        chk("R9 ovr cleared", ovr_err, 0);

        // R10 deferred disable
        on_mid = 1'b0;
        send(8'hE7, 1'b0, 1'b0, 3);
        chk("R10 active mid frame", on_mid, 1);
        chk("R10 frame completed", rx_data, 8'hE7);
        chk("R10 off after frame", rx_on, 0);
        strobe_buf();

        // R11 ignored while off
        irq0 = irq_cnt;
        send(8'h0F, 1'b0, 1'b0, -1);
        chk("R11 no load", buf_full, 0);
        chk("R11 no irq", irq_cnt - irq0, 0);
        chk("R11 data unchanged", rx_data, 8'hE7);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule